// File: doc/BRIEF.md
# Lockable Dual Comparator Control Register

This block is the digital control and status register for a pair of analog comparators. It holds one 32-bit word that a bus writes in a single cycle. The low half configures comparator A and the high half configures comparator B. The word drives the analog side through plain control outputs: enable, hysteresis level, speed/power level, inverting-input source, the comparator A input switch and window mode. The analog circuits themselves are not part of the block. They appear only as these control outputs and as two raw result bits.

Each half has a write-once lock bit. Once a half is locked, it ignores every later write, including a write that tries to clear the lock, until system reset. Safety firmware uses this to freeze a protection setup.

The raw comparator results pass through a two-flop synchronizer before they appear as read-only status bits. Separately, each result goes through a combinational path that works without the clock: polarity inversion, then enable gating, then a 3-bit selector that steers the result onto one of seven timer destination lines.

Top module: `dual_cmp_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every stored bit. After reset, `rd_data` reads 0 while the raw inputs are 0, and every control and destination output is 0.
- R2: Writing bit 15 as 1 locks the low half. From then on, bits 15:0 ignore every write, including writes that try to clear bit 15. Only reset clears the lock.
- R3: Bit 31 locks the high half (bits 31:16) in the same way. Each lock acts only on its own half.
- R4: Bits 14 and 30 read the raw results of comparator A and B (1 means the non-inverting input is higher) through a two-flop synchronizer. A raw change first reads back after the second rising edge. Writes to these bits have no effect.
- R5: Bits 7 and 17 always read 0 and ignore writes.
- R6: The selector fields are bits 10:8 (A) and 26:24 (B). Code k, for k from 1 to 7, drives destination bit k-1 and leaves the other destinations at 0. Code 0 drives no destination.
- R7: Polarity bits 11 (A) and 27 (B) invert the raw result before it is routed.
- R8: When an enable bit (bit 0 for A, bit 16 for B) is 0, all seven destinations of that comparator are 0, whatever the polarity.
- R9: The following fields drive the matching outputs:
  - hysteresis: bits 13:12 and 29:28
  - speed/power level: bits 3:2 and 19:18
  - inverting-input select: bits 6:4 and 22:20
- R10: Bit 1 drives `in_switch`, and bit 23 drives `window_en`.
- R11: A write takes effect at the clock edge that samples it. Without a write, the stored word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high system reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 32 | Write word |
| rd_data | output | 32 | Stored word with synchronized status bits merged |
| cmp_raw | input | 2 | Raw comparator results, bit 0 = A, bit 1 = B |
| cmp_en | output | 2 | Comparator enables |
| in_switch | output | 1 | Comparator A input switch |
| window_en | output | 1 | Window mode, ties B's non-inverting input to A's |
| hyst_a | output | 2 | Hysteresis level A |
| hyst_b | output | 2 | Hysteresis level B |
| speed_a | output | 2 | Speed/power level A |
| speed_b | output | 2 | Speed/power level B |
| neg_sel_a | output | 3 | Inverting-input source A |
| neg_sel_b | output | 3 | Inverting-input source B |
| dest_a | output | 7 | Timer destination lines for A |
| dest_b | output | 7 | Timer destination lines for B |

## Verification
The routing path is driven with a table of words that combine selector code, polarity, enable and raw level. Pairs in the table differ in one item, which separates a wrong destination index from a missing inversion or a missing enable gate. Another pair differs only in the raw level under inversion, so it shows that polarity is applied before gating. Directed sequences then lock one half and write the other. This tells an independent lock apart from a shared one, and a frozen lock bit apart from one that can be cleared. All-ones writes show that the status and reserved positions cannot be written, and a raw step sampled after one and after two edges pins the synchronizer depth.

// File: rtl/cmp_ctrl_pkg.sv
package cmp_ctrl_pkg;
  localparam int WORD_W   = 32;
  localparam int NUM_CMP  = 2;
  localparam int HALF_W   = WORD_W / NUM_CMP;
  localparam int SEL_W    = 3;
  localparam int NUM_DEST = (1 << SEL_W) - 1;

  // positions inside one 16-bit half
  localparam int P_EN     = 0;
  localparam int P_SWITCH = 1;
  localparam int P_SPEED  = 2;
  localparam int P_NEG    = 4;
  localparam int P_WINDOW = 7;
  localparam int P_SEL    = 8;
  localparam int P_POL    = 11;
  localparam int P_HYST   = 12;
  localparam int P_STAT   = 14;
  localparam int P_LOCK   = 15;

  // writable bits per half: A has the switch and a reserved bit 7,
  // B has window mode at bit 7 and a reserved bit 1
  localparam logic [HALF_W-1:0] MASK_A = 16'hBF7F;
  localparam logic [HALF_W-1:0] MASK_B = 16'hBFFD;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out
);
  logic [N-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= async_in;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign sync_out = stage[STAGES-1];
endmodule

// File: rtl/cmp_half_reg.sv
module cmp_half_reg #(
  parameter int                 W        = 16,
  parameter logic [W-1:0]       MASK     = '1,
  parameter int                 LOCK_POS = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_word,
  output logic [W-1:0] q
);
  logic locked;
  assign locked = q[LOCK_POS];

  always_ff @(posedge clk) begin
    if (rst)                   q <= '0;
    else if (wr_en && !locked) q <= wr_word & MASK;
  end

  // R2 and R3: a locked half never changes again
  assert_lock_hold_R2: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(q));

  // R11: no write, no change
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(q));
endmodule

// File: rtl/cmp_router.sv
module cmp_router #(
  parameter int SEL_W = 3,
  localparam int ND   = (1 << SEL_W) - 1
) (
  input  logic             en,
  input  logic             pol,
  input  logic [SEL_W-1:0] sel,
  input  logic             raw,
  output logic [ND-1:0]    dest
);
  logic cond;
  assign cond = en & (raw ^ pol);

  for (genvar k = 1; k <= ND; k++) begin : g_dest
    assign dest[k-1] = cond & (sel == SEL_W'(k));
  end
endmodule

// File: rtl/dual_cmp_ctrl.sv
module dual_cmp_ctrl
  import cmp_ctrl_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [WORD_W-1:0]   wr_data,
  output logic [WORD_W-1:0]   rd_data,
  input  logic [NUM_CMP-1:0]  cmp_raw,
  output logic [NUM_CMP-1:0]  cmp_en,
  output logic                in_switch,
  output logic                window_en,
  output logic [1:0]          hyst_a,
  output logic [1:0]          hyst_b,
  output logic [1:0]          speed_a,
  output logic [1:0]          speed_b,
  output logic [2:0]          neg_sel_a,
  output logic [2:0]          neg_sel_b,
  output logic [NUM_DEST-1:0] dest_a,
  output logic [NUM_DEST-1:0] dest_b
);
  logic [HALF_W-1:0]   half_q [NUM_CMP];
  logic [NUM_DEST-1:0] dest   [NUM_CMP];
  logic [NUM_CMP-1:0]  stat;

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_half
    cmp_half_reg #(
      .W(HALF_W), .MASK(g == 0 ? MASK_A : MASK_B), .LOCK_POS(P_LOCK)
    ) u_reg (
      .clk(clk), .rst(rst), .wr_en(wr_en),
      .wr_word(wr_data[g*HALF_W +: HALF_W]),
      .q(half_q[g])
    );

    cmp_router #(.SEL_W(SEL_W)) u_route (
      .en(half_q[g][P_EN]), .pol(half_q[g][P_POL]),
      .sel(half_q[g][P_SEL +: SEL_W]), .raw(cmp_raw[g]),
      .dest(dest[g])
    );

    assign cmp_en[g] = half_q[g][P_EN];
    assign rd_data[g*HALF_W +: HALF_W] =
      (half_q[g] & ~(HALF_W'(1) << P_STAT)) |
      (HALF_W'(stat[g]) << P_STAT);
  end

  cmp_sync #(.N(NUM_CMP), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .async_in(cmp_raw), .sync_out(stat)
  );

  assign in_switch = half_q[0][P_SWITCH];
  assign window_en = half_q[1][P_WINDOW];
  assign hyst_a    = half_q[0][P_HYST +: 2];
  assign hyst_b    = half_q[1][P_HYST +: 2];
  assign speed_a   = half_q[0][P_SPEED +: 2];
  assign speed_b   = half_q[1][P_SPEED +: 2];
  assign neg_sel_a = half_q[0][P_NEG +: 3];
  assign neg_sel_b = half_q[1][P_NEG +: 3];
  assign dest_a    = dest[0];
  assign dest_b    = dest[1];

  assert_onehot_route_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dest_a) && $onehot0(dest_b));

  assert_off_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (!cmp_en[0] |-> dest_a == '0) and (!cmp_en[1] |-> dest_b == '0));
endmodule

// File: tb/dual_cmp_ctrl_tb.sv
`timescale 1ns/1ps
module dual_cmp_ctrl_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        wr_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [1:0]  cmp_raw = '0;
  logic [1:0]  cmp_en;
  logic        in_switch, window_en;
  logic [1:0]  hyst_a, hyst_b, speed_a, speed_b;
  logic [2:0]  neg_sel_a, neg_sel_b;
  logic [6:0]  dest_a, dest_b;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  dual_cmp_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .cmp_raw(cmp_raw), .cmp_en(cmp_en), .in_switch(in_switch),
    .window_en(window_en), .hyst_a(hyst_a), .hyst_b(hyst_b),
    .speed_a(speed_a), .speed_b(speed_b), .neg_sel_a(neg_sel_a),
    .neg_sel_b(neg_sel_b), .dest_a(dest_a), .dest_b(dest_b)
  );

  typedef struct packed {
    logic [31:0] w;
    logic [1:0]  raw;
    logic [6:0]  ea;
    logic [6:0]  eb;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h0000_0000, 2'b11, 7'h00, 7'h00},
    '{32'h0000_0101, 2'b01, 7'h01, 7'h00},
    '{32'h0000_0F01, 2'b01, 7'h00, 7'h00},
    '{32'h0000_0F01, 2'b00, 7'h40, 7'h00},
    '{32'h0000_0B00, 2'b00, 7'h00, 7'h00},
    '{32'h0501_0000, 2'b10, 7'h00, 7'h10},
    '{32'h0C01_0201, 2'b01, 7'h02, 7'h08},
    '{32'h0E01_0000, 2'b10, 7'h00, 7'h00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] w);
    @(negedge clk); wr_en = 1; wr_data = w;
    @(negedge clk); wr_en = 0; wr_data = '0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 rd_data", rd_data, 32'h0);
    check("R1 controls", {30'h0, cmp_en}, 32'h0);
    check("R1 dests", {18'h0, dest_a, dest_b}, 32'h0);

    // R6 R7 R8 R4: table of routing vectors
    foreach (VECS[i]) begin
      cmp_raw = VECS[i].raw;
      do_write(VECS[i].w);
      repeat (2) @(negedge clk);
      check("R6/R7/R8 dest_a", {25'h0, dest_a}, {25'h0, VECS[i].ea});
      check("R6/R7/R8 dest_b", {25'h0, dest_b}, {25'h0, VECS[i].eb});
      check("R11 readback", rd_data,
            (VECS[i].w & 32'hBFFD_BF7F) |
            (32'(VECS[i].raw[0]) << 14) | (32'(VECS[i].raw[1]) << 30));
    end

    // R5 R4 R9 R10: all-but-lock write
    cmp_raw = 2'b00;
    do_write(32'h7FFF_7FFF);
    repeat (2) @(negedge clk);
    check("R5 reserved and R4 status ignore write", rd_data, 32'h3FFD_3F7F);
    check("R9 hyst", {28'h0, hyst_a, hyst_b}, 32'hF);
    check("R9 speed", {28'h0, speed_a, speed_b}, 32'hF);
    check("R9 neg_sel", {26'h0, neg_sel_a, neg_sel_b}, 32'h3F);
    check("R10 switch/window", {30'h0, in_switch, window_en}, 32'h3);

    // R4 synchronizer depth
    @(negedge clk); cmp_raw = 2'b11;
    @(negedge clk);
    check("R4 after one edge", {30'h0, rd_data[30], rd_data[14]}, 32'h0);
    @(negedge clk);
    check("R4 after two edges", {30'h0, rd_data[30], rd_data[14]}, 32'h3);
    cmp_raw = 2'b00;
    repeat (2) @(negedge clk);

    // R2 lock low half, R3 independence
    do_write(32'h0000_0000);
    do_write(32'h0000_8101);
    do_write(32'h0501_0000);
    check("R2 low half frozen, R3 high half free", rd_data, 32'h0501_8101);
    cmp_raw = 2'b01;
    #1;
    check("R6 route under lock", {25'h0, dest_a}, 32'h01);
    cmp_raw = 2'b00;
    do_write(32'h8000_0000);
    check("R3 high lock set", rd_data, 32'h8000_8101);
    do_write(32'h7FFF_7FFF);
    check("R2/R3 lock not clearable", rd_data, 32'h8000_8101);

    // R1 reset clears locks
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    @(negedge clk);
    check("R1 reset clears locks", rd_data, 32'h0);
    do_write(32'h0000_0001);
    check("R11 write after reset", rd_data, 32'h0000_0001);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule